// File: doc/BRIEF.md
# Dead-Time and Lost-Trigger Monitor

This block watches the trigger path of a multi-partition trigger controller, one bunch crossing per clock. For every partition it takes an inhibit flag and a trigger-request flag. It also takes a bunch-pattern flag that marks a crossing as active, an orbit marker, and four cause flags that explain why the master partition (partition 0) is blocked. During a run it counts:

- inhibited crossings, over all crossings and over active crossings only;
- triggers lost because they arrived while inhibited;
- triggers that were delivered;
- orbits.

For partition 0 it adds one counter per dead-time cause, a counter of empty crossings, and an event number that totals the triggers delivered across all partitions.

A small two-state run machine controls the counting. **IDLE** is the reset state. A run-start pulse moves it to **RUN** (transition START) and clears every counter. A run-stop pulse moves it back to IDLE (transition STOP) and the counters keep their values. If both pulses arrive in the same cycle, START wins. A start pulse while in RUN is a restart: the machine stays in RUN and clears the counters.

The block drives two gate outputs for external luminosity counters. The first shows that a run is in progress. The second is the inverted OR of every dead-time source. Software selects a partition and a counter index and reads the value one cycle later.

Top module: `deadtime_monitor`

## Requirements
- R1: After reset the state is IDLE, every counter is zero, and `rd_data`, `running_gate` and `live_gate` are 0.
- R2: `running_gate` is 1 exactly while the run machine is in RUN. In the cycle after a `run_start`, `running_gate` is 1. In the cycle after a `run_stop` that has no `run_start` beside it, `running_gate` is 0.
- R3: A `run_start` clears every counter. A crossing is counted only when the machine is in RUN and neither `run_start` nor `run_stop` is high in that crossing.
- R4: Counter index 0 of a partition counts counted crossings in which that partition's inhibit bit is 1.
- R5: Counter index 1 counts counted crossings that are both inhibited and active (`active_bx` = 1).
- R6: Counter index 2 (lost triggers) counts counted crossings that have both the inhibit bit and the request bit set.
- R7: Counter index 3 (delivered triggers) counts counted crossings that have the request bit set and the inhibit bit clear.
- R8: Counter index 4 is the orbit number. It counts counted crossings with `orbit_mark` = 1 and reads the same for every partition.
- R9: For partition 0, indices 5, 6, 7 and 8 count counted active crossings with `cause_flags` bit 0 (private orbit), bit 1 (subsystem status), bit 2 (throttling rules) and bit 3 (calibration/test cycle) set.
- R10: For partition 0, index 9 counts counted crossings with `active_bx` = 0. Index 10 is the event number: on each counted crossing it grows by the number of partitions that had a delivered trigger.
- R11: Indices 5 to 10 of partitions other than 0, and indices 11 to 15 of any partition, read 0.
- R12: `live_gate` is registered. One cycle after a crossing it is 1 only if no inhibit bit and no cause flag was set in that crossing.
- R13: `rd_data` is registered. It equals the counter selected by `rd_part`/`rd_sel` as it stood before the clock edge at which it was sampled.
- R14: Every counter is CW bits wide (32 by default) and wraps modulo 2^CW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one crossing per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_start | input | 1 | Run-start pulse: enter RUN and clear the counters |
| run_stop | input | 1 | Run-stop pulse: return to IDLE |
| orbit_mark | input | 1 | Orbit marker for this crossing |
| active_bx | input | 1 | Crossing is active in the bunch pattern |
| inhibit | input | NPART | Per-partition trigger inhibit |
| trig_req | input | NPART | Per-partition trigger request |
| cause_flags | input | 4 | Master-partition dead-time causes: private orbit, subsystem, throttle, calibration |
| rd_part | input | PW | Partition selected for readout |
| rd_sel | input | 4 | Counter index selected for readout |
| rd_data | output | CW | Selected counter value, one cycle later |
| running_gate | output | 1 | High while a run is in progress |
| live_gate | output | 1 | Registered inverted OR of all dead-time sources |

## Verification
A crossing's effect on the counters takes hold at the clock edge that samples it. The counter-value and gate results (`rd_data`, `running_gate`, `live_gate`) each appear after exactly one register stage, and `rd_data` shows the counter value from just before that edge. The bench's reference model therefore advances at every rising edge and takes its expected read value before it applies that crossing. The bench drives inputs and compares all three outputs at the falling edge, so each comparison lands half a cycle after the edge that produced the result. The bench is built with an 8-bit counter width so that the wrap in R14 is reached within a few hundred crossings.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    localparam int NUM_CAUSE    = 4;
    localparam int SEL_W        = 4;
    localparam int IDX_DEAD_ALL = 0;
    localparam int IDX_DEAD_ACT = 1;
    localparam int IDX_LOST     = 2;
    localparam int IDX_DELIV    = 3;
    localparam int IDX_ORBIT    = 4;
    localparam int IDX_CAUSE0   = 5;
    localparam int IDX_MISSING  = IDX_CAUSE0 + NUM_CAUSE;
    localparam int IDX_EVENT    = IDX_MISSING + 1;
endpackage

// File: rtl/dtm_run_fsm.sv
module dtm_run_fsm
    import dtm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_start,
    input  logic run_stop,
    output logic running,
    output logic count_en,
    output logic clear
);
    run_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (run_start) state_nx = ST_RUN;
            ST_RUN:  if (!run_start && run_stop) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        running  = 1'b0;
        count_en = 1'b0;
        unique case (state)
            ST_IDLE: running = 1'b0;
            ST_RUN: begin
                running  = 1'b1;
                count_en = !run_start && !run_stop;
            end
            default: running = 1'b0;
        endcase
        clear = run_start;
    end

    assert_start_enters_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> running);
    assert_stop_leaves_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_stop && !run_start) |=> !running);
    assert_no_count_in_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !count_en);
endmodule

// File: rtl/dtm_part_counters.sv
module dtm_part_counters #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          count_en,
    input  logic          inhibit,
    input  logic          trig_req,
    input  logic          active_bx,
    output logic [CW-1:0] dead_all,
    output logic [CW-1:0] dead_act,
    output logic [CW-1:0] lost,
    output logic [CW-1:0] deliv
);
    localparam int NC = 4;
    logic [NC-1:0] hit;
    logic [CW-1:0] cnt [NC];

    always_comb hit = {trig_req & ~inhibit, inhibit & trig_req, inhibit & active_bx, inhibit};

    for (genvar i = 0; i < NC; i++) begin : g_cnt
        logic [CW-1:0] c;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 c <= '0;
            else if (clear)             c <= '0;
            else if (count_en && hit[i]) c <= c + 1'b1;
        end
        assign cnt[i] = c;
    end

    assign dead_all = cnt[0];
    assign dead_act = cnt[1];
    assign lost     = cnt[2];
    assign deliv    = cnt[3];

    assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (dead_all == '0 && dead_act == '0 && lost == '0 && deliv == '0));
    assert_open_crossing_no_dead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !inhibit) |=> ($stable(dead_all) && $stable(dead_act) && $stable(lost)));
    assert_lost_excludes_deliv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |=> !(!$stable(lost) && !$stable(deliv)));
endmodule

// File: rtl/dtm_global_counters.sv
module dtm_global_counters
    import dtm_pkg::*;
#(
    parameter int CW    = 32,
    parameter int NPART = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 count_en,
    input  logic                 active_bx,
    input  logic                 orbit_mark,
    input  logic [NUM_CAUSE-1:0] cause_flags,
    input  logic [NPART-1:0]     deliv_vec,
    output logic [CW-1:0]        cause_cnt [NUM_CAUSE],
    output logic [CW-1:0]        missing,
    output logic [CW-1:0]        event_num,
    output logic [CW-1:0]        orbit_num
);
    localparam int SW = $clog2(NPART + 1);
    logic [SW-1:0] n_deliv;

    always_comb begin
        n_deliv = '0;
        for (int i = 0; i < NPART; i++) n_deliv = n_deliv + SW'(deliv_vec[i]);
    end

    for (genvar k = 0; k < NUM_CAUSE; k++) begin : g_cause
        logic [CW-1:0] c;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    c <= '0;
            else if (clear)                                c <= '0;
            else if (count_en && active_bx && cause_flags[k]) c <= c + 1'b1;
        end
        assign cause_cnt[k] = c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            missing   <= '0;
            event_num <= '0;
            orbit_num <= '0;
        end else if (clear) begin
            missing   <= '0;
            event_num <= '0;
            orbit_num <= '0;
        end else if (count_en) begin
            if (!active_bx) missing   <= missing + 1'b1;
            if (orbit_mark) orbit_num <= orbit_num + 1'b1;
            event_num <= event_num + CW'(n_deliv);
        end
    end

    assert_event_step_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |=> ((event_num - $past(event_num)) <= CW'(NPART)));
    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clear) |=> ($stable(event_num) && $stable(orbit_num) && $stable(missing)));
endmodule

// File: rtl/deadtime_monitor.sv
module deadtime_monitor
    import dtm_pkg::*;
#(
    parameter int CW    = 32,
    parameter int NPART = 8,
    parameter int PW    = (NPART > 1) ? $clog2(NPART) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_start,
    input  logic                 run_stop,
    input  logic                 orbit_mark,
    input  logic                 active_bx,
    input  logic [NPART-1:0]     inhibit,
    input  logic [NPART-1:0]     trig_req,
    input  logic [NUM_CAUSE-1:0] cause_flags,
    input  logic [PW-1:0]        rd_part,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [CW-1:0]        rd_data,
    output logic                 running_gate,
    output logic                 live_gate
);
    logic running, count_en, clear;
    logic [CW-1:0] p_all [NPART];
    logic [CW-1:0] p_act [NPART];
    logic [CW-1:0] p_lost [NPART];
    logic [CW-1:0] p_deliv [NPART];
    logic [CW-1:0] cause_cnt [NUM_CAUSE];
    logic [CW-1:0] missing, event_num, orbit_num;
    logic [CW-1:0] sel_val;
    logic [NPART-1:0] deliv_vec;

    dtm_run_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .run_stop(run_stop),
        .running(running), .count_en(count_en), .clear(clear)
    );

    for (genvar p = 0; p < NPART; p++) begin : g_part
        dtm_part_counters #(.CW(CW)) u_pc (
            .clk(clk), .rst_n(rst_n), .clear(clear), .count_en(count_en),
            .inhibit(inhibit[p]), .trig_req(trig_req[p]), .active_bx(active_bx),
            .dead_all(p_all[p]), .dead_act(p_act[p]), .lost(p_lost[p]), .deliv(p_deliv[p])
        );
    end

    assign deliv_vec = trig_req & ~inhibit;

    dtm_global_counters #(.CW(CW), .NPART(NPART)) u_glb (
        .clk(clk), .rst_n(rst_n), .clear(clear), .count_en(count_en),
        .active_bx(active_bx), .orbit_mark(orbit_mark), .cause_flags(cause_flags),
        .deliv_vec(deliv_vec), .cause_cnt(cause_cnt), .missing(missing),
        .event_num(event_num), .orbit_num(orbit_num)
    );

    always_comb begin
        sel_val = '0;
        if (int'(rd_part) < NPART) begin
            if (int'(rd_sel) == IDX_DEAD_ALL)      sel_val = p_all[rd_part];
            else if (int'(rd_sel) == IDX_DEAD_ACT) sel_val = p_act[rd_part];
            else if (int'(rd_sel) == IDX_LOST)     sel_val = p_lost[rd_part];
            else if (int'(rd_sel) == IDX_DELIV)    sel_val = p_deliv[rd_part];
            else if (int'(rd_sel) == IDX_ORBIT)    sel_val = orbit_num;
            else if (rd_part == '0) begin
                if (int'(rd_sel) >= IDX_CAUSE0 && int'(rd_sel) < IDX_MISSING)
                    sel_val = cause_cnt[int'(rd_sel) - IDX_CAUSE0];
                else if (int'(rd_sel) == IDX_MISSING) sel_val = missing;
                else if (int'(rd_sel) == IDX_EVENT)   sel_val = event_num;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data      <= '0;
            running_gate <= 1'b0;
            live_gate    <= 1'b0;
        end else begin
            rd_data      <= sel_val;
            running_gate <= running_nx();
            live_gate    <= !(|inhibit || |cause_flags);
        end
    end

    function automatic logic running_nx();
        if (run_start)     return 1'b1;
        else if (run_stop) return 1'b0;
        else               return running;
    endfunction

    assert_gate_tracks_fsm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running_gate == running);
    assert_live_low_when_dead_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|inhibit || |cause_flags) |=> !live_gate);
    assert_unused_index_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_sel) > IDX_EVENT) |=> (rd_data == '0));
endmodule

// File: tb/sim_deadtime_monitor.sv
`timescale 1ns/1ps
module sim_deadtime_monitor;
    localparam int CW = 8;
    localparam int NP = 8;
    localparam int PW = 3;
    localparam longint MASK = (64'd1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_start = 0, run_stop = 0, orbit_mark = 0, active_bx = 0;
    logic [NP-1:0] inhibit = '0, trig_req = '0;
    logic [3:0] cause_flags = '0;
    logic [PW-1:0] rd_part = '0;
    logic [3:0] rd_sel = '0;
    logic [CW-1:0] rd_data;
    logic running_gate, live_gate;

    always #2.5 clk = ~clk;

    deadtime_monitor #(.CW(CW), .NPART(NP), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .run_stop(run_stop),
        .orbit_mark(orbit_mark), .active_bx(active_bx), .inhibit(inhibit),
        .trig_req(trig_req), .cause_flags(cause_flags), .rd_part(rd_part),
        .rd_sel(rd_sel), .rd_data(rd_data), .running_gate(running_gate),
        .live_gate(live_gate)
    );

    int checks = 0;
    int errors = 0;
    bit chk_en = 0;
    string tag_override = "";

    longint m_cnt [NP][4];
    longint m_cause [4];
    longint m_orbit, m_missing, m_event;
    bit m_run;
    longint exp_rd;
    bit exp_run, exp_live;

    function automatic longint model_read(int p, int s);
        if (s < 4) return m_cnt[p][s];
        if (s == 4) return m_orbit;
        if (p != 0) return 0;
        if (s < 9) return m_cause[s-5];
        if (s == 9) return m_missing;
        if (s == 10) return m_event;
        return 0;
    endfunction

    function automatic string req_of(int p, int s);
        if (tag_override != "") return tag_override;
        case (s)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            5, 6, 7, 8: return (p == 0) ? "R9" : "R11";
            9, 10: return (p == 0) ? "R10" : "R11";
            default: return "R11";
        endcase
    endfunction

    task automatic check_eq(string tag, longint act, longint exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp_v, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cnt[p, k]) m_cnt[p][k] = 0;
            foreach (m_cause[k]) m_cause[k] = 0;
            m_orbit = 0; m_missing = 0; m_event = 0; m_run = 0;
            exp_rd = 0; exp_run = 0; exp_live = 0;
        end else begin
            bit cnt_now;
            exp_rd = model_read(int'(rd_part), int'(rd_sel)) & MASK;
            exp_live = !((|inhibit) || (|cause_flags));
            cnt_now = m_run && !run_start && !run_stop;
            if (run_start) begin
                foreach (m_cnt[p, k]) m_cnt[p][k] = 0;
                foreach (m_cause[k]) m_cause[k] = 0;
                m_orbit = 0; m_missing = 0; m_event = 0;
            end
            if (cnt_now) begin
                for (int p = 0; p < NP; p++) begin
                    if (inhibit[p]) m_cnt[p][0]++;
                    if (inhibit[p] && active_bx) m_cnt[p][1]++;
                    if (inhibit[p] && trig_req[p]) m_cnt[p][2]++;
                    if (!inhibit[p] && trig_req[p]) begin
                        m_cnt[p][3]++;
                        m_event++;
                    end
                end
                if (orbit_mark) m_orbit++;
                if (!active_bx) m_missing++;
                for (int k = 0; k < 4; k++) if (active_bx && cause_flags[k]) m_cause[k]++;
            end
            if (run_start) m_run = 1;
            else if (run_stop) m_run = 0;
            exp_run = m_run;
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            check_eq({req_of(int'(rd_part), int'(rd_sel)), "/R13 rd_data"}, rd_data, exp_rd);
            check_eq("R2 running_gate", running_gate, exp_run);
            check_eq("R12 live_gate", live_gate, exp_live);
        end
    end

    task automatic tick(bit st, bit sp, bit orb, bit act, logic [NP-1:0] inh,
                        logic [NP-1:0] req, logic [3:0] cf, int p, int s);
        @(negedge clk);
        run_start = st; run_stop = sp; orbit_mark = orb; active_bx = act;
        inhibit = inh; trig_req = req; cause_flags = cf;
        rd_part = PW'(p); rd_sel = 4'(s);
    endtask

    task automatic rand_tick(int p, int s);
        tick(($urandom_range(0, 199) == 0), ($urandom_range(0, 249) == 0),
             ($urandom_range(0, 15) == 0), $urandom_range(0, 3) != 0,
             NP'($urandom), NP'($urandom), 4'($urandom & $urandom), p, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        check_eq("R1 rd_data", rd_data, 0);
        check_eq("R1 running_gate", running_gate, 0);
        check_eq("R1 live_gate", live_gate, 0);
        rst_n = 1'b1;
        chk_en = 1;
        // R3: idle crossings are not counted
        repeat (5) tick(0, 0, 1, 1, '1, '1, 4'hF, 0, 0);
        tick(0, 0, 0, 1, '0, '0, 0, 0, 0);
        @(negedge clk);
        check_eq("R3 idle count", rd_data, 0);
        // start a run, directed patterns
        tick(1, 0, 0, 1, '1, '0, 0, 0, 0);
        tick(0, 0, 1, 1, 8'h01, 8'h03, 4'h1, 0, 0);
        tick(0, 0, 0, 0, 8'h01, 8'h01, 4'h2, 0, 1);
        tick(0, 0, 1, 1, 8'h00, 8'hFF, 4'h0, 0, 2);
        tick(0, 0, 0, 1, 8'hF0, 8'hFF, 4'hC, 0, 3);
        tick(0, 0, 0, 1, 8'h00, 8'h00, 0, 0, 4);
        for (int s = 0; s < 16; s++) tick(0, 0, 0, 1, '0, '0, 0, 0, s);
        tick(0, 0, 0, 1, '0, '0, 0, 0, 0);
        // random traffic with random readout
        for (int i = 0; i < 3000; i++) rand_tick($urandom_range(0, NP-1), $urandom_range(0, 15));
        // stop and start in the same cycle: start wins (R2)
        tick(1, 1, 0, 1, '0, '0, 0, 0, 0);
        tick(0, 0, 0, 1, '0, '0, 0, 0, 0);
        @(negedge clk);
        check_eq("R2 start wins", running_gate, 1);
        check_eq("R3 cleared after restart", rd_data, 0);
        for (int i = 0; i < 2000; i++) rand_tick($urandom_range(0, NP-1), $urandom_range(0, 15));
        // stop: counters hold, sweep every index
        tick(0, 1, 0, 1, '0, '0, 0, 0, 0);
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < 16; s++)
                rand_tick(p, s);
        // R14: wrap modulo 2^CW
        tick(1, 0, 0, 1, '0, '0, 0, 0, 0);
        tag_override = "R14";
        for (int i = 0; i < 300; i++) tick(0, 0, 1, 1, '1, '1, 4'hF, 0, i % 5);
        tick(0, 1, 0, 1, '0, '0, 0, 0, 0);
        tick(0, 0, 0, 1, '0, '0, 0, 0, 0);
        @(negedge clk);
        check_eq("R14 wrapped dead count", rd_data, 300 % 256);
        tag_override = "";
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule